// File: doc/BRIEF.md
# General-purpose I/O port with peripheral overrides

This block is a small general-purpose I/O port of up to eight pins. Each pin has an output-latch bit and a direction bit, both held in registers that a simple bus writes. A pin-read path carries the pad level through a two-flop synchronizer so that software sees a stable value. Peripherals sharing a pin can take over two things through per-pin enable/value pairs: the value driven onto the pad, and whether the pad's digital input is let through at all.

When no override is asserted, the input gate follows the chip state: open while awake, closed in sleep. Whenever the gate is closed, the peripheral tap and the synchronizer input both see 0, so a floating pad cannot toggle logic. The peripheral tap is taken ahead of the synchronizer, so a peripheral that uses it brings its own synchronizer. It depends only on the pad and the input gate, so an edge detector on a pin still sees the pad while another function drives it.

The block holds no sequencing state beyond its registers and the synchronizer. The bus is one write port and one combinational read port, selected by a two-bit register code.

Top module: `gpio_alt_port`

## Requirements
- R1: On reset, the output-latch and direction registers are 0, every `pad_oe` bit is 0 and the synchronized pin value is 0.
- R2: When `wr_en` is 1 at a clock edge, address code 0 loads `wr_data` into the output latch and code 1 loads it into the direction register. Reading with `rd_addr` 0 or 1 returns that register from the next cycle on.
- R3: `pad_oe` of each pin equals its direction bit (1 = drive, 0 = high impedance).
- R4: On a driven pin whose output-override enable is 1, `pad_out` equals the override value, whatever the latch bit.
- R5: On a driven pin whose output-override enable is 0, `pad_out` equals the latch bit.
- R6: On an undriven pin, `pad_out` is 0 whatever the latch bit and the output override.
- R7: When a pin's input-gate override enable is 1, the gate is open if the override value is 1 and closed if it is 0, in both sleep and normal state.
- R8: When a pin's input-gate override enable is 0, the gate is open while `sleep` is 0 and closed while `sleep` is 1.
- R9: `raw_in` equals `pad_in` on a pin with an open gate and 0 on a pin with a closed gate, unaffected by the direction bit, the latch bit and the output override.
- R10: Reading with `rd_addr` 2 returns the gated pad value delayed by two clock edges.
- R11: Writes with address code 2 or 3 change no register, and reading with `rd_addr` 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register code (0 latch, 1 direction) |
| wr_data | input | NPINS | Write data |
| rd_addr | input | 2 | Read register code (0 latch, 1 direction, 2 pins, 3 none) |
| rd_data | output | NPINS | Combinational read data |
| sleep | input | 1 | Chip sleep state |
| pv_ovr_en | input | NPINS | Per-pin output-value override enable |
| pv_ovr_val | input | NPINS | Per-pin output-value override value |
| die_ovr_en | input | NPINS | Per-pin input-gate override enable |
| die_ovr_val | input | NPINS | Per-pin input-gate override value |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad driver enables |
| raw_in | output | NPINS | Gated, unsynchronized input tap for peripherals |

## Verification
The bench builds the port with NPINS=3 and the default two-stage synchronizer. With three pins, all 256 combinations of sleep, output-override pair, latch bit, direction bit, input-gate override pair and pad level can be swept. Each pin gets a different rotation of the combination index, so the pins never move in lockstep. A separate step times a pad edge against the read path one clock at a time, and the register codes without a register are written and read to confirm they have no effect.

// File: rtl/gpio_alt_pkg.sv
package gpio_alt_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_LATCH = 2'd0,
        REG_DIR   = 2'd1,
        REG_PINS  = 2'd2,
        REG_NONE  = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
    input  logic drive_en,
    input  logic latch_bit,
    input  logic pv_en,
    input  logic pv_val,
    input  logic gate_ovr_en,
    input  logic gate_ovr_val,
    input  logic sleep,
    input  logic pad_in,
    output logic pad_out,
    output logic raw_in
);

    logic out_sel;
    logic gate_open;

    always_comb begin
        out_sel   = pv_en ? pv_val : latch_bit;
        pad_out   = drive_en & out_sel;
        gate_open = gate_ovr_en ? gate_ovr_val : ~sleep;
        raw_in    = pad_in & gate_open;
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= '0;
        end else begin
            chain_q[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_alt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_reg_e        wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  gpio_reg_e        rd_sel,
    input  logic [WIDTH-1:0] pin_val,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_LATCH: latch_q <= wr_data;
                REG_DIR:   dir_q   <= wr_data;
                REG_PINS,
                REG_NONE:  ;
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel)
            REG_LATCH: rd_data = latch_q;
            REG_DIR:   rd_data = dir_q;
            REG_PINS:  rd_data = pin_val;
            REG_NONE:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port
    import gpio_alt_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]      wr_data,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [NPINS-1:0]      rd_data,
    input  logic                  sleep,
    input  logic [NPINS-1:0]      pv_ovr_en,
    input  logic [NPINS-1:0]      pv_ovr_val,
    input  logic [NPINS-1:0]      die_ovr_en,
    input  logic [NPINS-1:0]      die_ovr_val,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    output logic [NPINS-1:0]      raw_in
);

    logic [NPINS-1:0] latch_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] pin_sync;
    gpio_reg_e        wr_sel;
    gpio_reg_e        rd_sel;

    assign wr_sel = gpio_reg_e'(wr_addr);
    assign rd_sel = gpio_reg_e'(rd_addr);

    gpio_regs #(.WIDTH(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .pin_val (pin_sync),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .rd_data (rd_data)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_pin_mux u_mux (
            .drive_en     (dir_q[i]),
            .latch_bit    (latch_q[i]),
            .pv_en        (pv_ovr_en[i]),
            .pv_val       (pv_ovr_val[i]),
            .gate_ovr_en  (die_ovr_en[i]),
            .gate_ovr_val (die_ovr_val[i]),
            .sleep        (sleep),
            .pad_in       (pad_in[i]),
            .pad_out      (pad_out[i]),
            .raw_in       (raw_in[i])
        );
    end

    assign pad_oe = dir_q;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (pin_sync)
    );

endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk
    import gpio_alt_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] wr_addr,
    input logic [NPINS-1:0]      wr_data,
    input logic [REG_ADDR_W-1:0] rd_addr,
    input logic [NPINS-1:0]      rd_data,
    input logic                  sleep,
    input logic [NPINS-1:0]      die_ovr_en,
    input logic [NPINS-1:0]      die_ovr_val,
    input logic [NPINS-1:0]      pad_out,
    input logic [NPINS-1:0]      pad_oe,
    input logic [NPINS-1:0]      raw_in
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_DIR) |=> (pad_oe == $past(wr_data)));

    assert_undriven_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    assert_gate_forced_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_in & die_ovr_en & ~die_ovr_val) == '0));

    assert_sleep_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ((raw_in & ~die_ovr_en) == '0));

    assert_ro_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == REG_PINS || wr_addr == REG_NONE)) |=> $stable(pad_oe));

    assert_none_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == REG_NONE) |-> (rd_data == '0));

    if (SYNC_STAGES == 2) begin : g_lat
        assert_sync_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && rd_addr == REG_PINS) |-> (rd_data == $past(raw_in, 2)));
    end

endmodule

bind gpio_alt_port gpio_alt_port_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .sleep       (sleep),
    .die_ovr_en  (die_ovr_en),
    .die_ovr_val (die_ovr_val),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .raw_in      (raw_in)
);

// File: tb/tb_gpio_alt_port.sv
module tb_gpio_alt_port;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         sleep = 1'b0;
    logic [N-1:0] pv_ovr_en = '0;
    logic [N-1:0] pv_ovr_val = '0;
    logic [N-1:0] die_ovr_en = '0;
    logic [N-1:0] die_ovr_val = '0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic [N-1:0] raw_in;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gpio_alt_port #(.NPINS(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sleep(sleep), .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val),
        .die_ovr_en(die_ovr_en), .die_ovr_val(die_ovr_val), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .raw_in(raw_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] rv;
        logic [N-1:0] exp_oe, exp_out, exp_raw;
        logic [6:0]   v;
        logic         gate;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pad_oe == '0, "R1 pad_oe", pad_oe, 0);
        read_reg(2'd0, rv); check(rv == '0, "R1 latch", rv, 0);
        read_reg(2'd1, rv); check(rv == '0, "R1 dir", rv, 0);
        read_reg(2'd2, rv); check(rv == '0, "R1 pins", rv, 0);

        // R2 register write and readback
        write_reg(2'd0, 3'b101);
        write_reg(2'd1, 3'b011);
        read_reg(2'd0, rv); check(rv == 3'b101, "R2 latch", rv, 5);
        read_reg(2'd1, rv); check(rv == 3'b011, "R2 dir", rv, 3);

        // R11 writes to codes 2 and 3 are ignored, code 3 reads 0
        write_reg(2'd2, 3'b010);
        write_reg(2'd3, 3'b110);
        read_reg(2'd0, rv); check(rv == 3'b101, "R11 latch kept", rv, 5);
        read_reg(2'd1, rv); check(rv == 3'b011, "R11 dir kept", rv, 3);
        check(pad_oe == 3'b011, "R11 pad_oe kept", pad_oe, 3);
        read_reg(2'd3, rv); check(rv == '0, "R11 none reads 0", rv, 0);

        // R10 latency: pad edge visible after exactly two clock edges
        write_reg(2'd1, '0);
        pad_in = '0;
        repeat (3) @(negedge clk);
        pad_in = 3'b111;
        read_reg(2'd2, rv); check(rv == '0, "R10 lag0", rv, 0);
        @(negedge clk);
        read_reg(2'd2, rv); check(rv == '0, "R10 lag1", rv, 0);
        @(negedge clk);
        read_reg(2'd2, rv); check(rv == 3'b111, "R10 lag2", rv, 7);

        // Exhaustive sweep: per-pin bits {pad,gval,gen,dir,latch,pval,pen}
        for (int c = 0; c < 256; c++) begin
            logic [N-1:0] lat, dir;
            sleep = c[7];
            for (int i = 0; i < N; i++) begin
                v = 7'((c + i * 53) % 128);
                pv_ovr_en[i]   = v[0];
                pv_ovr_val[i]  = v[1];
                lat[i]         = v[2];
                dir[i]         = v[3];
                die_ovr_en[i]  = v[4];
                die_ovr_val[i] = v[5];
                pad_in[i]      = v[6];
            end
            write_reg(2'd0, lat);
            write_reg(2'd1, dir);
            @(negedge clk);
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                exp_oe[i]  = dir[i];
                exp_out[i] = dir[i] ? (pv_ovr_en[i] ? pv_ovr_val[i] : lat[i]) : 1'b0;
                gate       = die_ovr_en[i] ? die_ovr_val[i] : ~sleep;
                exp_raw[i] = pad_in[i] & gate;
                if (!dir[i])
                    check(pad_out[i] == 1'b0, "R6 undriven", pad_out[i], 0);
                else if (pv_ovr_en[i])
                    check(pad_out[i] == exp_out[i], "R4 override out", pad_out[i], exp_out[i]);
                else
                    check(pad_out[i] == exp_out[i], "R5 latch out", pad_out[i], exp_out[i]);
                if (die_ovr_en[i])
                    check(raw_in[i] == exp_raw[i], "R7 gate override", raw_in[i], exp_raw[i]);
                else
                    check(raw_in[i] == exp_raw[i], "R8 sleep gate", raw_in[i], exp_raw[i]);
            end
            check(pad_oe == exp_oe, "R3 pad_oe", pad_oe, exp_oe);
            check(raw_in == exp_raw, "R9 raw tap", raw_in, exp_raw);
            read_reg(2'd2, rv);
            check(rv == exp_raw, "R10 pin read", rv, exp_raw);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule